// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is the serial test port of a memory device. A four-wire port (test clock, mode select, serial data in and serial data out) steps a sixteen-state controller. Under the controller's direction, bits are shifted through one of several registers placed between serial in and serial out: a 3-bit instruction register, a 1-bit bypass stage, a 32-bit identification register and a boundary register of configurable length. The boundary register samples the device's functional pins and holds values that can drive them.

There is no dedicated test reset pin. The port returns to its reset state at power-up (`por_n`, synchronous to `tck`, active low) or when mode select is held high for five rising edges. The active instruction decides which data register is used and whether the functional outputs are overridden. Under one instruction the boundary register drives the outputs. Under another, every functional output is forced to high impedance while the pins are still sampled.

Top module: `scan_port`

## Requirements
- R1: After `por_n` is low on a rising edge, the controller is in its reset state, the active instruction is IDCODE (code 001), `tdo_oe`, `drive_en` and `force_hiz` are 0 and `bnd_drive` is all zeros.
- R2: From any state, five rising `tck` edges with `tms` high reach the reset state, and the active instruction becomes IDCODE on the fifth edge. After four such edges the instruction is unchanged.
- R3: `tms` and `tdi` are sampled on rising `tck`, and `tdo` changes on falling `tck`. `tdo_oe` is 1 only in the shift states (data or instruction) and 0 otherwise. Registers shift out least significant bit first.
- R4: The instruction register is 3 bits wide. Capture-IR loads binary 001 into it, so the first three bits shifted out are 1, 0, 0.
- R5: A shifted instruction does not change `drive_en` or `force_hiz` until the controller passes through Update-IR.
- R6: The instruction codes are 000 EXTEST, 001 IDCODE, 010 SAMPLE-Z, 100 SAMPLE/PRELOAD and 111 BYPASS. Codes 011, 101 and 110 select the bypass stage.
- R7: The bypass stage is one bit. It captures 0 in Capture-DR and delays `tdi` by one shift.
- R8: Under IDCODE, Capture-DR loads the 32-bit `ID_VALUE` parameter with bit 0 forced to 1.
- R9: Under EXTEST, SAMPLE-Z and SAMPLE/PRELOAD, Capture-DR loads the boundary register. Cell i takes `pin_in[i]` where `PIN_MASK[i]` is 1, and a constant 1 where it is 0.
- R10: `bnd_drive` takes the boundary shift contents on the edge that leaves Update-DR, but only under the three boundary instructions. At every other time, and under any other instruction, it holds its value.
- R11: `drive_en` is 1 exactly while EXTEST is active, and `force_hiz` is 1 exactly while SAMPLE-Z is active.
- R12: The controller follows the standard sixteen-state graph. Detours through Exit1, Pause and Exit2 leave the shift contents intact, and Select-IR with `tms` high goes to reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, sampled on rising `tck` |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| pin_in | input | BSR_LEN | Sampled levels of the functional pins |
| tdo | output | 1 | Serial data out, valid when `tdo_oe` is 1 |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bnd_drive | output | BSR_LEN | Boundary update stage toward the pins |
| drive_en | output | 1 | Functional pins take `bnd_drive` (EXTEST) |
| force_hiz | output | 1 | Functional outputs forced to high impedance (SAMPLE-Z) |

## Verification
The assertions assume that `por_n` is held low for at least one rising edge before any traffic, so that state, instruction and output-enable flops start from known values. They also assume that `tms` and `tdi` are stable around the rising edge. The stimulus holds reset for several cycles, changes `tms` and `tdi` only one time unit after a falling edge, and reads `tdo` just before the next rising edge. The five-edge reset check counts consecutive high `tms` samples, so it does not depend on any particular starting state. The stimulus enters that sequence from a pause state that sits deep in the graph.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
// Shared types for the scan port: controller states, instruction codes
// and the data-register selector. Assumes a 3-bit instruction register.
package scan_pkg;

    typedef enum logic [3:0] {
        ST_RESET,    ST_IDLE,
        ST_SEL_DR,   ST_CAP_DR,  ST_SHIFT_DR, ST_EXIT1_DR,
        ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
        ST_SEL_IR,   ST_CAP_IR,  ST_SHIFT_IR, ST_EXIT1_IR,
        ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
    } tap_state_t;

    localparam int IR_W = 3;
    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_EXTEST  = 3'b000;
    localparam instr_t OP_IDCODE  = 3'b001;
    localparam instr_t OP_SAMPZ   = 3'b010;
    localparam instr_t OP_PRELOAD = 3'b100;
    localparam instr_t OP_BYPASS  = 3'b111;

    // Value loaded into the instruction shift stage in Capture-IR
    localparam instr_t IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDENT,
        DR_BOUND
    } dr_sel_t;

    // Map an instruction to the data register it places on the scan path
    function automatic dr_sel_t decode_dr(input instr_t op);
        case (op)
            OP_EXTEST, OP_SAMPZ, OP_PRELOAD: return DR_BOUND;
            OP_IDCODE:                       return DR_IDENT;
            default:                         return DR_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/scan_fsm.sv
`timescale 1ns/1ps
// Sixteen-state test controller. Advances on every rising tck edge
// according to tms. Assumes por_n is synchronous to tck.
module scan_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_t state,
    output tap_state_t state_nx
);

    // Next-state function of the controller graph
    always_comb begin
        case (state)
            ST_RESET:    state_nx = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_nx = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   state_nx = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   state_nx = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: state_nx = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: state_nx = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: state_nx = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: state_nx = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   state_nx = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   state_nx = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   state_nx = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: state_nx = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: state_nx = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: state_nx = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: state_nx = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   state_nx = tms ? ST_SEL_DR   : ST_IDLE;
            default:     state_nx = ST_RESET;
        endcase
    end

    // State register, forced to reset by power-on
    always_ff @(posedge tck) begin
        if (!por_n) state <= ST_RESET;
        else        state <= state_nx;
    end

endmodule

// File: rtl/scan_ir.sv
`timescale 1ns/1ps
// Instruction register: a shift stage on the scan path and an active
// stage that is written only in Update-IR. The active stage returns to
// IDCODE at power-on and on every edge that enters the reset state.
module scan_ir
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  tap_state_t state,
    input  logic       enter_reset,
    input  logic       tdi,
    output instr_t     ir_active,
    output logic       ir_lsb
);

    instr_t ir_shift;

    // Shift stage: capture the fixed pattern, then shift toward bit 0
    always_ff @(posedge tck) begin
        if (!por_n) begin
            ir_shift <= '0;
        end else if (state == ST_CAP_IR) begin
            ir_shift <= IR_CAPTURE;
        end else if (state == ST_SHIFT_IR) begin
            ir_shift <= {tdi, ir_shift[IR_W-1:1]};
        end
    end

    // Active stage: reload IDCODE on reset, take shift stage on update
    always_ff @(posedge tck) begin
        if (!por_n || enter_reset) begin
            ir_active <= OP_IDCODE;
        end else if (state == ST_UPD_IR) begin
            ir_active <= ir_shift;
        end
    end

    assign ir_lsb = ir_shift[0];

endmodule

// File: rtl/scan_dr.sv
`timescale 1ns/1ps
// Data registers: bypass stage, identification register and boundary
// register with its update stage. Only the register that the active
// instruction selects captures, shifts or updates.
module scan_dr
    import scan_pkg::*;
#(
    parameter int                   BSR_LEN  = 12,
    parameter logic [BSR_LEN-1:0]   PIN_MASK = '1,
    parameter logic [31:0]          ID_VALUE = 32'h0000_0001
) (
    input  logic               tck,
    input  logic               por_n,
    input  tap_state_t         state,
    input  dr_sel_t            sel,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] bnd_drive
);

    localparam int          ID_W   = 32;
    localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};

    logic               capture;
    logic               shift;
    logic               byp_q;
    logic [ID_W-1:0]    id_sh;
    logic [BSR_LEN-1:0] bsr_sh;
    logic [BSR_LEN-1:0] bsr_cap;

    assign capture = (state == ST_CAP_DR);
    assign shift   = (state == ST_SHIFT_DR);

    // Per-cell capture source: pin level, or constant 1 for unbonded cells
    for (genvar g = 0; g < BSR_LEN; g++) begin : g_cell
        assign bsr_cap[g] = PIN_MASK[g] ? pin_in[g] : 1'b1;
    end

    // Bypass stage: captures 0 and passes tdi with one stage of delay
    always_ff @(posedge tck) begin
        if (!por_n)                                byp_q <= 1'b0;
        else if (capture && sel == DR_BYPASS)      byp_q <= 1'b0;
        else if (shift && sel == DR_BYPASS)        byp_q <= tdi;
    end

    // Identification register: captures the constant, shifts toward bit 0
    always_ff @(posedge tck) begin
        if (!por_n)                                id_sh <= '0;
        else if (capture && sel == DR_IDENT)       id_sh <= ID_CAP;
        else if (shift && sel == DR_IDENT)         id_sh <= {tdi, id_sh[ID_W-1:1]};
    end

    // Boundary shift stage: captures pins, shifts toward cell 0
    always_ff @(posedge tck) begin
        if (!por_n)                                bsr_sh <= '0;
        else if (capture && sel == DR_BOUND)       bsr_sh <= bsr_cap;
        else if (shift && sel == DR_BOUND)         bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
    end

    // Boundary update stage: written when leaving Update-DR
    always_ff @(posedge tck) begin
        if (!por_n)                                     bnd_drive <= '0;
        else if (state == ST_UPD_DR && sel == DR_BOUND) bnd_drive <= bsr_sh;
    end

    // Serial output of the selected register
    always_comb begin
        case (sel)
            DR_IDENT: dr_lsb = id_sh[0];
            DR_BOUND: dr_lsb = bsr_sh[0];
            default:  dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_port.sv
`timescale 1ns/1ps
// Test access port top: controller, instruction register, data
// registers and the falling-edge serial output stage. Assumes tck runs
// while por_n is low so the synchronous reset takes effect.
module scan_port
    import scan_pkg::*;
#(
    parameter int                 BSR_LEN  = 12,
    parameter logic [BSR_LEN-1:0] PIN_MASK = 12'b1011_1101_1110,
    parameter logic [31:0]        ID_VALUE = 32'h1234_5678
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] bnd_drive,
    output logic               drive_en,
    output logic               force_hiz
);

    tap_state_t tap_state;
    tap_state_t tap_next;
    instr_t     ir_active;
    logic       ir_lsb;
    logic       dr_lsb;
    dr_sel_t    dr_sel;

    scan_fsm i_fsm (
        .tck      (tck),
        .por_n    (por_n),
        .tms      (tms),
        .state    (tap_state),
        .state_nx (tap_next)
    );

    scan_ir i_ir (
        .tck         (tck),
        .por_n       (por_n),
        .state       (tap_state),
        .enter_reset (tap_next == ST_RESET),
        .tdi         (tdi),
        .ir_active   (ir_active),
        .ir_lsb      (ir_lsb)
    );

    assign dr_sel = decode_dr(ir_active);

    scan_dr #(
        .BSR_LEN  (BSR_LEN),
        .PIN_MASK (PIN_MASK),
        .ID_VALUE (ID_VALUE)
    ) i_dr (
        .tck       (tck),
        .por_n     (por_n),
        .state     (tap_state),
        .sel       (dr_sel),
        .tdi       (tdi),
        .pin_in    (pin_in),
        .dr_lsb    (dr_lsb),
        .bnd_drive (bnd_drive)
    );

    // Pin control follows the active instruction
    assign drive_en  = (ir_active == OP_EXTEST);
    assign force_hiz = (ir_active == OP_SAMPZ);

    // Serial output stage: updated on the falling edge, enabled in shift states
    always_ff @(negedge tck) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (tap_state == ST_SHIFT_IR) ? ir_lsb : dr_lsb;
            tdo_oe <= (tap_state == ST_SHIFT_IR) || (tap_state == ST_SHIFT_DR);
        end
    end

endmodule

// File: rtl/scan_port_chk.sv
`timescale 1ns/1ps
// Property checker for scan_port, attached by bind. Observes the
// controller state, the active instruction and the top-level outputs.
module scan_port_chk
    import scan_pkg::*;
#(
    parameter int BSR_LEN = 12
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdo_oe,
    input  tap_state_t         state,
    input  instr_t             ir_active,
    input  logic [BSR_LEN-1:0] bnd_drive
);

    logic [2:0] ones_cnt;

    // Count consecutive rising edges with tms high, saturating at five
    always_ff @(posedge tck) begin
        if (!por_n)          ones_cnt <= '0;
        else if (!tms)       ones_cnt <= '0;
        else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    // R2: five high tms samples always land in the reset state
    a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
        (ones_cnt == 3'd5) |-> (state == ST_RESET));

    // R1: the reset state always holds IDCODE as the active instruction
    a_r1_reset_idcode: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_RESET) |-> (ir_active == OP_IDCODE));

    // R3: serial output only enabled while a shift state is current
    a_r3_oe_in_shift: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == ST_SHIFT_DR || state == ST_SHIFT_IR));

    // R5: the active instruction moves only on Update-IR or a reset entry
    a_r5_ir_hold: assert property (@(posedge tck) disable iff (!por_n)
        (state != ST_UPD_IR && state != ST_RESET && !(state == ST_SEL_IR && tms))
        |=> $stable(ir_active));

    // R10: pin drive values move only on the edge leaving Update-DR
    a_r10_update_only: assert property (@(posedge tck) disable iff (!por_n)
        (state != ST_UPD_DR) |=> $stable(bnd_drive));

endmodule

bind scan_port scan_port_chk #(.BSR_LEN(BSR_LEN)) i_chk (
    .tck       (tck),
    .por_n     (por_n),
    .tms       (tms),
    .tdo_oe    (tdo_oe),
    .state     (tap_state),
    .ir_active (ir_active),
    .bnd_drive (bnd_drive)
);

// File: tb/test_scan_port.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver tasks queue the expected serial bits and
// a monitor compares tdo against the queue whenever tdo_oe is high.
module test_scan_port;

    localparam int              N    = 12;
    localparam logic [N-1:0]    MASK = 12'b1011_1101_1110;
    localparam logic [31:0]     IDV  = 32'h1234_5678;

    logic         tck = 1'b0;
    logic         por_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic [N-1:0] pin_in = '0;
    logic         tdo, tdo_oe, drive_en, force_hiz;
    logic [N-1:0] bnd_drive;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;
    bit    exp_q[$];
    string tag_q[$];

    scan_port #(.BSR_LEN(N), .PIN_MASK(MASK), .ID_VALUE(IDV)) i_scan_port (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .bnd_drive(bnd_drive),
        .drive_en(drive_en), .force_hiz(force_hiz)
    );

    always #2.5 tck = ~tck;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [N-1:0] capv(input logic [N-1:0] p);
        return (p & MASK) | ~MASK;
    endfunction

    task automatic tick(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
    endtask

    task automatic settle();
        @(negedge tck);
        #2;
    endtask

    // From Run-Test/Idle: load an instruction, check R4 capture and R5 hold
    task automatic shift_ir(input logic [2:0] code);
        logic od, oh;
        od = drive_en;
        oh = force_hiz;
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        exp_q.push_back(1'b1); tag_q.push_back("R4 capture bit0");
        exp_q.push_back(1'b0); tag_q.push_back("R4 capture bit1");
        exp_q.push_back(1'b0); tag_q.push_back("R4 capture bit2");
        for (int i = 0; i < 3; i++) tick(i == 2, code[i]);
        tick(1, 0);
        chk("R5 held in Exit1-IR", {drive_en, force_hiz}, {od, oh});
        tick(0, 0);
        chk("R5 held in Update-IR", {drive_en, force_hiz}, {od, oh});
        settle();
    endtask

    // From Run-Test/Idle: shift n bits, optional pause after pause_at bits (R12)
    task automatic shift_dr(input int n, input logic [63:0] din,
                            input logic [63:0] expv, input string tag, input int pause_at);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(expv[i]);
            tag_q.push_back(tag);
        end
        for (int i = 0; i < n; i++) begin
            tick((i == n - 1) || (i == pause_at - 1), din[i]);
            if (i == pause_at - 1 && i != n - 1) begin
                tick(0, 0);
                chk("R3 oe low in Exit1-DR", tdo_oe, 0);
                tick(0, 0);
                tick(1, 0);
                chk("R3 oe low in Pause-DR", tdo_oe, 0);
                tick(0, 0);
            end
        end
        tick(1, 0);
        tick(0, 0);
        settle();
    endtask

    // Monitor: compare every enabled tdo bit against the scoreboard
    initial begin
        forever begin
            @(negedge tck);
            #2;
            if (tdo_oe === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected shift bit", 1, 0);
                end else begin
                    string t;
                    t = tag_q.pop_front();
                    chk(t, tdo, exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge tck);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: power-on reset state
        repeat (4) @(negedge tck);
        #2;
        chk("R1 tdo_oe after reset", tdo_oe, 0);
        chk("R1 drive_en after reset", drive_en, 0);
        chk("R1 force_hiz after reset", force_hiz, 0);
        chk("R1 bnd_drive after reset", bnd_drive, 0);
        por_n = 1'b1;
        tick(0, 0);
        settle();

        // R1 R8 R3: IDCODE active after reset, LSB first, bit0 forced
        shift_dr(32, 64'h0, {32'h0, IDV | 32'h1}, "R8 ID after power-on", 0);

        // R6 R7 R11: bypass
        shift_ir(3'b111);
        chk("R11 bypass drive_en", drive_en, 0);
        chk("R11 bypass force_hiz", force_hiz, 0);
        shift_dr(8, 64'hA5, 64'hA5 << 1, "R7 bypass path", 0);

        // R6: reserved codes behave as bypass
        for (int k = 0; k < 3; k++) begin
            logic [2:0] c;
            c = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
            shift_ir(c);
            shift_dr(8, 64'h3C, 64'h3C << 1, "R6 reserved code as bypass", 0);
        end

        // R6: explicit IDCODE
        shift_ir(3'b001);
        shift_dr(32, 64'h0, {32'h0, IDV | 32'h1}, "R6 IDCODE selects ID", 0);

        // R9 R10 R12: SAMPLE/PRELOAD with a pause in the middle
        pin_in = 12'h5A3;
        shift_ir(3'b100);
        chk("R11 preload drive_en", drive_en, 0);
        chk("R11 preload force_hiz", force_hiz, 0);
        shift_dr(N, 64'h3C9, {52'h0, capv(12'h5A3)}, "R9 preload capture", 5);
        chk("R12 R10 preload through pause", bnd_drive, 12'h3C9);

        // R11 R10: EXTEST
        pin_in = 12'hA5C;
        shift_ir(3'b000);
        chk("R11 extest drive_en", drive_en, 1);
        chk("R11 extest force_hiz", force_hiz, 0);
        chk("R10 held across IR update", bnd_drive, 12'h3C9);
        shift_dr(N, 64'h0F0, {52'h0, capv(12'hA5C)}, "R9 extest capture", 0);
        chk("R10 extest update", bnd_drive, 12'h0F0);

        // R10: no update under bypass
        shift_ir(3'b111);
        shift_dr(8, 64'h81, 64'h81 << 1, "R7 bypass again", 0);
        chk("R10 bypass leaves bnd_drive", bnd_drive, 12'h0F0);

        // R5 R11 R9: EXTEST then SAMPLE-Z
        shift_ir(3'b000);
        shift_ir(3'b010);
        chk("R11 samplez force_hiz", force_hiz, 1);
        chk("R11 samplez drive_en", drive_en, 0);
        pin_in = 12'h777;
        shift_dr(N, 64'h111, {52'h0, capv(12'h777)}, "R9 samplez capture", 0);
        chk("R10 samplez update", bnd_drive, 12'h111);

        // R2 R12: five ones from Pause-DR
        tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(1, 0);
        chk("R2 four ones keep instruction", force_hiz, 1);
        tick(0, 0);
        chk("R2 fifth one clears force_hiz", force_hiz, 0);
        chk("R2 fifth one clears drive_en", drive_en, 0);
        chk("R3 oe low in reset", tdo_oe, 0);
        settle();
        shift_dr(32, 64'h0, {32'h0, IDV | 32'h1}, "R2 ID after tms reset", 0);

        settle();
        chk("R3 all expected bits shifted", exp_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule